// File: doc/BRIEF.md
# Fall-Through Shift Queue

A first-in first-out queue made of a chain of word cells, each with its own valid bit. A word that is accepted enters the top cell (cell 0). On each following clock it moves one cell toward the output end (cell DEPTH-1) as long as the cell ahead of it is free or is being vacated in that same cycle. The oldest word therefore sits in the output cell. A read takes that word and deletes it, and every word behind it steps one cell closer to the output.

The write strobe and the read strobe are separate and can be used independently within one clock domain. An occupancy count includes words that are still falling through the chain, so the full indication is exact at every cycle. Writes are refused only when the queue is full and no read is being accepted in the same cycle. A read attempted while the output cell is still empty has no effect and raises an underflow indication in that cycle.

Top module: `shift_fall_fifo`

## Requirements
- R1: After reset the count is 0, `empty` is 1, `full` is 0 and `rd_valid` is 0.
- R2: A write into an empty queue is accepted at the clock edge where `wr_en` is high. Its word enters cell 0 and `rd_valid` rises exactly DEPTH-1 clock edges later, not sooner.
- R3: A stored word advances one cell per clock while the next cell is free or is being vacated. Words leave in the order in which they were accepted.
- R4: `rd_valid` is 1 only while cell DEPTH-1 holds a word. It is 0 whenever the queue is empty, and `rd_data` is that word.
- R5: A read with `rd_valid` high deletes the output word at the clock edge. The next older word reaches the output one cycle later if it was directly behind. Without a write in the same cycle, the count drops by one.
- R6: A read while `rd_valid` is 0 is ignored: no word is removed and the count is not reduced. `underflow` is 1 combinationally in that cycle and 0 at all other times.
- R7: `count` equals the number of accepted words not yet read, including words still in transit. `full` is 1 exactly when count equals DEPTH, and `empty` is 1 exactly when count is 0.
- R8: A write while `full` is 1 and no accepted read is present is dropped. The count is unchanged and the dropped word never appears at the output.
- R9: A read with `rd_valid` high together with a write are both accepted, also when full. The count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read-and-delete strobe |
| rd_data | output | WIDTH | Word in the output cell |
| rd_valid | output | 1 | Output cell holds a word |
| underflow | output | 1 | Read attempted while the output cell is empty |
| full | output | 1 | All DEPTH words are held |
| empty | output | 1 | No word is held |
| count | output | $clog2(DEPTH+1) | Number of words held, in transit or not |

## Verification
The hardest situation to reach is a queue that holds words but whose output cell is still empty. In that state a read must be refused while the count stays above zero. A closely related case is a read of a full chain in the same cycle as a write, where every cell shifts at once and cell 0 is refilled.

Directed steps reach both states. One writes and then reads in the very next cycle. Another fills the chain back to back and then reads and writes together. Random stimulus with a high write rate and a low read rate then keeps words in transit and the queue near full for long stretches. A position-tracking model in the bench predicts every output in every cycle.

// File: rtl/shift_fall_fifo_pkg.sv
package shift_fall_fifo_pkg;

  // occupancy after one clock, given accepted write and read
  function automatic int unsigned occ_next(input int unsigned occ,
                                           input logic put, input logic take);
    int unsigned r;
    r = occ;
    if (put && !take) r = occ + 1;
    if (take && !put) r = occ - 1;
    return r;
  endfunction

  // a word may enter the top cell when a slot is left or one is freed
  function automatic logic accept_put(input logic want, input logic is_full,
                                      input logic take);
    return want && (!is_full || take);
  endfunction

endpackage

// File: rtl/fall_cell.sv
module fall_cell #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_in,
  input  logic [WIDTH-1:0] data_in,
  input  logic             leave,
  output logic             hold_q,
  output logic [WIDTH-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (fill_in) begin
        hold_q <= 1'b1;
        data_q <= data_in;
      end else if (leave) begin
        hold_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put,
  input  logic          take,
  output logic [CW-1:0] occ,
  output logic          is_full,
  output logic          is_empty
);
  import shift_fall_fifo_pkg::*;

  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= CW'(occ_next(int'(occ), put, take));
  end

  assign is_full  = (occ == TOP);
  assign is_empty = (occ == '0);

endmodule

// File: rtl/shift_fall_fifo.sv
module shift_fall_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             underflow,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  import shift_fall_fifo_pkg::*;

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] held;
  logic [DEPTH-1:0] moving;
  logic [WIDTH-1:0] cell_data [DEPTH];

  // named events for the checker
  logic wr_fire;
  logic rd_fire;

  assign rd_fire   = rd_en && held[LAST];
  assign wr_fire   = accept_put(wr_en, full, rd_fire);
  assign underflow = rd_en && !held[LAST];

  assign rd_valid = held[LAST];
  assign rd_data  = cell_data[LAST];

  // a word moves unless every cell ahead of it is held and nothing leaves
  assign moving[LAST] = rd_fire;
  generate
    for (genvar i = 0; i < LAST; i++) begin : g_move
      assign moving[i] = held[i] && (!(&held[LAST:i+1]) || rd_fire);
    end
  endgenerate

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      if (i == 0) begin : g_top
        fall_cell #(.WIDTH(WIDTH)) cell_i (
          .clk    (clk),
          .rst_n  (rst_n),
          .fill_in(wr_fire),
          .data_in(wr_data),
          .leave  (moving[0]),
          .hold_q (held[0]),
          .data_q (cell_data[0])
        );
      end else begin : g_rest
        fall_cell #(.WIDTH(WIDTH)) cell_i (
          .clk    (clk),
          .rst_n  (rst_n),
          .fill_in(moving[i-1]),
          .data_in(cell_data[i-1]),
          .leave  (moving[i]),
          .hold_q (held[i]),
          .data_q (cell_data[i])
        );
      end
    end
  endgenerate

  occ_counter #(.DEPTH(DEPTH)) occ_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .put     (wr_fire),
    .take    (rd_fire),
    .occ     (count),
    .is_full (full),
    .is_empty(empty)
  );

endmodule

// File: rtl/shift_fall_fifo_chk.sv
module shift_fall_fifo_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          underflow,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] count,
  input logic          wr_fire,
  input logic          rd_fire
);

  // R2
  write_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !full && !rd_en |=> count == $past(count) + 1'b1);

  // R5
  read_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_valid && !wr_en |=> count == $past(count) - 1'b1);

  // R6
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !wr_en |=> $stable(count));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en |=> $stable(count));

  // R9
  rdwr_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_valid && wr_en |=> $stable(count));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4
  empty_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_valid);

  // R6
  fire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(underflow && rd_fire));

  // R8
  full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_en |-> !wr_fire);

endmodule

bind shift_fall_fifo shift_fall_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .underflow(underflow),
  .full     (full),
  .empty    (empty),
  .count    (count),
  .wr_fire  (wr_fire),
  .rd_fire  (rd_fire)
);

// File: tb/shift_fall_fifo_tb_top.sv
module shift_fall_fifo_tb_top;
  localparam int PERIOD = 10;
  localparam int W = 8;
  localparam int D = 4;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, underflow, full, empty;
  logic [CW-1:0] count;

  int checks = 0;
  int errors = 0;

  // model: index 0 is the oldest word, m_pos is its cell number
  int m_n = 0;
  int m_pos [D];
  logic [W-1:0] m_data [D];

  shift_fall_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .underflow(underflow), .full(full), .empty(empty), .count(count)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic m_out_valid();
    return (m_n > 0) && (m_pos[0] == D - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic w, input logic [W-1:0] dat, input logic r);
    logic take, put;
    int lim;
    take = r && m_out_valid();
    put  = w && ((m_n < D) || take);
    if (take) begin
      for (int k = 0; k < D - 1; k++) begin
        m_pos[k]  = m_pos[k+1];
        m_data[k] = m_data[k+1];
      end
      m_n--;
    end
    lim = D - 1;
    for (int k = 0; k < m_n; k++) begin
      if (m_pos[k] < lim) m_pos[k] = m_pos[k] + 1;
      lim = m_pos[k] - 1;
    end
    if (put) begin
      m_pos[m_n]  = 0;
      m_data[m_n] = dat;
      m_n++;
    end
  endtask

  task automatic compare();
    chk("R7 count", 32'(count), 32'(m_n));
    chk("R7 full", 32'(full), 32'(m_n == D));
    chk("R7 empty", 32'(empty), 32'(m_n == 0));
    chk("R4 rd_valid", 32'(rd_valid), 32'(m_out_valid()));
    if (m_out_valid()) chk("R3 order", 32'(rd_data), 32'(m_data[0]));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic w, input logic [W-1:0] dat, input logic r);
    wr_en = w; wr_data = dat; rd_en = r;
    #1;
    chk("R6 underflow", 32'(underflow), 32'(r && !m_out_valid()));
    model_step(w, dat, r);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 fall-through latency on an empty queue
    step(1'b1, 8'hA5, 1'b0);
    for (int i = 1; i < D - 1; i++) step(1'b0, 8'h00, 1'b0);
    chk("R2 not yet at output", 32'(rd_valid), 0);
    step(1'b0, 8'h00, 1'b0);
    chk("R2 arrived", 32'(rd_valid), 1);
    chk("R2 data", 32'(rd_data), 32'hA5);
    step(1'b0, 8'h00, 1'b1);
    chk("R5 emptied", 32'(count), 0);

    // R6 read while the word is still in transit
    step(1'b1, 8'h3C, 1'b0);
    step(1'b0, 8'h00, 1'b1);
    chk("R6 count kept", 32'(count), 1);
    while (!rd_valid) step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b1);

    // R8 fill back to back, then write while full
    for (int i = 0; i < D + 2; i++) step(1'b1, 8'(8'h10 + i), 1'b0);
    chk("R8 count at full", 32'(count), D);
    chk("R8 full", 32'(full), 1);
    // R9 read and write together while full
    step(1'b1, 8'hEE, 1'b1);
    chk("R9 count same", 32'(count), D);
    // R5 drain in order
    for (int i = 0; i < 3 * D; i++) step(1'b0, 8'h00, 1'b1);
    chk("R5 drained", 32'(empty), 1);

    // random mix, write-heavy then read-heavy
    for (int i = 0; i < 3000; i++) begin
      logic w, r;
      if (i < 1500) begin
        w = ($urandom % 4) != 0;
        r = ($urandom % 4) == 0;
      end else begin
        w = ($urandom % 3) == 0;
        r = ($urandom % 3) != 0;
      end
      step(w, 8'($urandom), r);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule